// File: doc/BRIEF.md
# Double-Buffered I2S Audio Transmitter

This block plays stereo audio from a bus-mapped sample memory onto a three-wire serial audio link. A host writes up to 16 stereo frames, each a left word and a right word, into a 32-word memory. Once transmission is enabled, the block streams the frames in order and wraps back to the first frame, so playback never stops. The memory is treated as two halves. A status flag is raised as each half is consumed, which gives the host time to refill that half while the other half plays.

A build parameter selects the clocking role. In the master build, the bit clock and word select are derived from the system clock through a programmable divider. In the slave build, the block follows an external bit clock and word select, which are resynchronised into the system clock domain. The sample resolution is programmable. Samples are stored right-aligned in their 32-bit word, and each one is sent MSB first in a 32-bit channel slot.

Top module: `i2s_pingpong_tx`

## Requirements
- R1: After reset, irq and sd_out are 0 and the status register reads 0. The read-only identity word at offset 0x0 reads 0x1B1 in the master build and 0x191 in the slave build; writes to it have no effect.
- R2: Each bus access gives a one-cycle bus_ack in the cycle after the strobe, with read data valid alongside it. The control word at offset 0x1 holds enable in bit 0, the divider in bits 15:8 and the resolution in bits 23:16, and reads back those fields with all other bits 0. The mask at offset 0x2 holds bits 1:0.
- R3: The sample memory occupies offsets 0x20 to 0x3F. Frame i has its left word at 0x20+2i and its right word at 0x20+2i+1. Every word reads back what was written.
- R4: On the serial line, word select low carries the left channel and high carries the right. Each channel slot is 32 bit clocks long. Data and word select change only on a falling bit clock edge, and the MSB follows one bit clock after the word-select change.
- R5: Playback sends frames 0 through 15 in order, left before right, and then wraps to frame 0.
- R6: With resolution N, the low N bits of the stored word are sent MSB first, followed by zeros to fill the slot. A setting below 16 acts as 16 and a setting above 32 acts as 32.
- R7: Status bit 0 is set when the right word of frame 7 is loaded for sending, and bit 1 when that of frame 15 is. Each bit stays set until the host writes 1 to it; writing 0 leaves it unchanged. A set and a clear in the same cycle leave the bit set.
- R8: irq is high exactly when some status bit is set whose mask bit is also set.
- R9: Setting enable starts playback at frame 0 at the next left-channel boundary. Clearing enable lets the frame in progress finish, after which only zeros are sent.
- R10: In the master build, the bit clock period is 2*(divider+1) system clocks.
- R11: In the slave build, the block follows the external bit clock and word select and produces the same stream. Its sck_out and ws_out are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_stb | input | 1 | Bus access strobe, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle access acknowledge |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| irq | output | 1 | Half-buffer interrupt |
| sck_in | input | 1 | External bit clock (slave build) |
| ws_in | input | 1 | External word select (slave build) |
| sck_out | output | 1 | Generated bit clock (master build) |
| ws_out | output | 1 | Generated word select (master build) |
| sd_out | output | 1 | Serial audio data |

## Verification
The bench runs a serial receiver model on the line. Each decoded word is compared with the value expected from the frame index and the resolution. As a result, a read pointer that skips or repeats a frame, a wrong alignment shift or a lost slot bit shows up as a mismatched word within one frame time. A pointer that does not wrap shows up in the 33rd and 34th decoded words. A status flag that is set at the wrong point, or that does not clear, shows up on irq and on a status read as soon as a half has drained. A serializer that keeps running after enable is cleared leaves nonzero words beyond the one frame that is allowed to finish.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  localparam int SLOT_W = 32;
  localparam int DIV_W  = 8;
  localparam int RES_W  = 8;

  localparam int REG_ID   = 0;
  localparam int REG_CTRL = 1;
  localparam int REG_MASK = 2;
  localparam int REG_STAT = 3;

  // Left-justify the low `res` bits of a stored sample into a slot word.
  function automatic logic [SLOT_W-1:0] align_sample(input logic [SLOT_W-1:0] w,
                                                     input logic [RES_W-1:0] res);
    logic [5:0]        r;
    logic [SLOT_W-1:0] keep;
    if (res < RES_W'(16))      r = 6'd16;
    else if (res > RES_W'(32)) r = 6'd32;
    else                       r = res[5:0];
    keep = (32'd1 << r) - 32'd1;
    return (w & keep) << (6'd32 - r);
  endfunction

  function automatic logic [31:0] id_word(input bit master);
    return 32'h0000_0191 | (master ? 32'h0000_0020 : 32'h0);
  endfunction

endpackage

// File: rtl/i2s_clk_master.sv
module i2s_clk_master
  import i2s_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             ws,
  output logic             fall_ev,
  output logic             ws_next
);
  localparam int BITW = $clog2(SLOT_W);

  logic [DIV_W-1:0] cnt_q;
  logic [BITW-1:0]  bit_q;
  logic             sck_q, ws_q;
  logic             tick;

  assign tick    = (cnt_q >= div);
  assign fall_ev = tick && sck_q;
  assign ws_next = (bit_q == BITW'(SLOT_W-1)) ? ~ws_q : ws_q;
  assign sck     = sck_q;
  assign ws      = ws_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bit_q <= '0;
      sck_q <= 1'b0;
      ws_q  <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick) sck_q <= ~sck_q;
      if (fall_ev) begin
        bit_q <= bit_q + 1'b1;
        ws_q  <= ws_next;
      end
    end
  end
endmodule

// File: rtl/i2s_clk_follow.sv
module i2s_clk_follow (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_ext,
  input  logic ws_ext,
  output logic fall_ev,
  output logic ws_next
);
  logic [2:0] sck_sync;
  logic [1:0] ws_sync;

  assign fall_ev = sck_sync[2] && !sck_sync[1];
  assign ws_next = ws_sync[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sync <= '0;
      ws_sync  <= '0;
    end else begin
      sck_sync <= {sck_sync[1:0], sck_ext};
      ws_sync  <= {ws_sync[0], ws_ext};
    end
  end
endmodule

// File: rtl/i2s_serializer.sv
module i2s_serializer
  import i2s_tx_pkg::*;
#(
  parameter int FRAMES = 16,
  localparam int PTRW = $clog2(FRAMES),
  localparam int IDXW = PTRW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_ev,
  input  logic              ws_next,
  input  logic              enable,
  input  logic [RES_W-1:0]  res,
  input  logic [SLOT_W-1:0] rd_word,
  output logic [IDXW-1:0]   rd_idx,
  output logic              sd,
  output logic [1:0]        half_evt,
  output logic [PTRW-1:0]   ptr
);
  logic              ws_prev, run_q, sd_q;
  logic [SLOT_W-1:0] shreg;
  logic [PTRW-1:0]   ptr_q;
  logic              edge_ev, right_load;

  assign edge_ev    = fall_ev && (ws_next != ws_prev);
  assign right_load = edge_ev && ws_next && run_q;
  assign rd_idx     = {ptr_q, ws_next};
  assign sd         = sd_q;
  assign ptr        = ptr_q;

  always_comb begin
    half_evt[0] = right_load && (ptr_q == PTRW'(FRAMES/2 - 1));
    half_evt[1] = right_load && (ptr_q == PTRW'(FRAMES - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_prev <= 1'b0;
      run_q   <= 1'b0;
      sd_q    <= 1'b0;
      shreg   <= '0;
      ptr_q   <= '0;
    end else if (fall_ev) begin
      ws_prev <= ws_next;
      sd_q    <= shreg[SLOT_W-1];
      if (edge_ev) begin
        if (!ws_next) begin
          run_q <= enable;
          shreg <= enable ? align_sample(rd_word, res) : '0;
        end else begin
          shreg <= run_q ? align_sample(rd_word, res) : '0;
          if (!run_q)                             ptr_q <= '0;
          else if (ptr_q == PTRW'(FRAMES - 1))    ptr_q <= '0;
          else                                    ptr_q <= ptr_q + 1'b1;
        end
      end else begin
        shreg <= {shreg[SLOT_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/i2s_pingpong_tx.sv
module i2s_pingpong_tx
  import i2s_tx_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  parameter int FRAMES    = 16,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ack,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              sck_in,
  input  logic              ws_in,
  output logic              sck_out,
  output logic              ws_out,
  output logic              sd_out
);
  localparam int WORDS = 2 * FRAMES;
  localparam int BUFW  = $clog2(WORDS);
  localparam int PTRW  = $clog2(FRAMES);
  localparam logic [ADDR_W-1:0] BUF_BASE = ADDR_W'(WORDS);

  logic [SLOT_W-1:0] mem [WORDS];
  logic              en_q, ack_q;
  logic [DIV_W-1:0]  div_q;
  logic [RES_W-1:0]  res_q;
  logic [1:0]        mask_q, stat_q;
  logic [31:0]       rdata_q, rd_val;

  logic              access, wr, is_buf;
  logic [BUFW-1:0]   buf_idx;
  logic              fall_ev, ws_next;
  logic [BUFW-1:0]   ser_idx;
  logic [1:0]        half_evt;
  logic [PTRW-1:0]   ser_ptr;

  assign access  = bus_stb && !ack_q;
  assign wr      = access && bus_we;
  assign is_buf  = (bus_addr >= BUF_BASE);
  assign buf_idx = bus_addr[BUFW-1:0];

  generate
    if (IS_MASTER) begin : g_master
      logic unused_ext;
      assign unused_ext = sck_in ^ ws_in;
      i2s_clk_master u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (div_q),
        .sck     (sck_out),
        .ws      (ws_out),
        .fall_ev (fall_ev),
        .ws_next (ws_next)
      );
    end else begin : g_slave
      logic unused_div;
      assign unused_div = ^div_q;
      assign sck_out = 1'b0;
      assign ws_out  = 1'b0;
      i2s_clk_follow u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_ext (sck_in),
        .ws_ext  (ws_in),
        .fall_ev (fall_ev),
        .ws_next (ws_next)
      );
    end
  endgenerate

  i2s_serializer #(.FRAMES(FRAMES)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_ev  (fall_ev),
    .ws_next  (ws_next),
    .enable   (en_q),
    .res      (res_q),
    .rd_word  (mem[ser_idx]),
    .rd_idx   (ser_idx),
    .sd       (sd_out),
    .half_evt (half_evt),
    .ptr      (ser_ptr)
  );

  always_comb begin
    rd_val = '0;
    if (is_buf) rd_val = mem[buf_idx];
    else begin
      case (bus_addr)
        ADDR_W'(REG_ID):   rd_val = id_word(IS_MASTER);
        ADDR_W'(REG_CTRL): rd_val = {8'h00, res_q, div_q, 7'h00, en_q};
        ADDR_W'(REG_MASK): rd_val = {30'h0, mask_q};
        ADDR_W'(REG_STAT): rd_val = {30'h0, stat_q};
        default:           rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
      en_q    <= 1'b0;
      div_q   <= '0;
      res_q   <= '0;
      mask_q  <= '0;
      stat_q  <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      ack_q <= access;
      if (access) rdata_q <= rd_val;
      if (wr && is_buf) mem[buf_idx] <= bus_wdata;
      if (wr && !is_buf && bus_addr == ADDR_W'(REG_CTRL)) begin
        en_q  <= bus_wdata[0];
        div_q <= bus_wdata[15:8];
        res_q <= bus_wdata[23:16];
      end
      if (wr && !is_buf && bus_addr == ADDR_W'(REG_MASK)) mask_q <= bus_wdata[1:0];
      if (wr && !is_buf && bus_addr == ADDR_W'(REG_STAT))
        stat_q <= (stat_q & ~bus_wdata[1:0]) | half_evt;
      else
        stat_q <= stat_q | half_evt;
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
  assign irq       = |(stat_q & mask_q);
endmodule

// File: rtl/i2s_tx_checker.sv
module i2s_tx_checker #(
  parameter bit IS_MASTER = 1'b1,
  parameter int ADDR_W    = 6,
  parameter int PTRW      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_stb,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack,
  input logic              irq,
  input logic              sck_out,
  input logic              ws_out,
  input logic              sd_out,
  input logic [1:0]        half_evt,
  input logic [1:0]        stat_q,
  input logic [1:0]        mask_q,
  input logic [PTRW-1:0]   ptr
);
  logic clr0_ev;
  assign clr0_ev = bus_stb && bus_we && !bus_ack && bus_addr == ADDR_W'(3) &&
                   bus_wdata[0] && !half_evt[0];

  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  p_low_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    half_evt[0] |=> stat_q[0]);

  p_high_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    half_evt[1] |=> stat_q[1]);

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr0_ev |=> !stat_q[0]);

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != 2'b00));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    half_evt[1] |=> (ptr == '0));

  generate
    if (IS_MASTER) begin : g_master_props
      p_ws_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws_out) |-> $fell(sck_out));
      p_sd_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_out) |-> $fell(sck_out));
    end else begin : g_slave_props
      p_no_clk_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_out && !ws_out);
    end
  endgenerate
endmodule

bind i2s_pingpong_tx i2s_tx_checker #(
  .IS_MASTER (IS_MASTER),
  .ADDR_W    (ADDR_W),
  .PTRW      (PTRW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_stb   (bus_stb),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ack   (bus_ack),
  .irq       (irq),
  .sck_out   (sck_out),
  .ws_out    (ws_out),
  .sd_out    (sd_out),
  .half_evt  (half_evt),
  .stat_q    (stat_q),
  .mask_q    (mask_q),
  .ptr       (ser_ptr)
);

// File: tb/i2s_pingpong_tx_tb.sv
`timescale 1ns/1ps
module i2s_pingpong_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb_m = 1'b0, stb_s = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic ack_m, ack_s, irq_m, irq_s;
  logic [31:0] rd_m, rd_s;
  logic sck_m, ws_m, sd_m, sd_s, sck_so, ws_so;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2s_pingpong_tx #(.IS_MASTER(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_stb(stb_m), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_ack(ack_m), .bus_rdata(rd_m), .irq(irq_m),
    .sck_in(1'b0), .ws_in(1'b0), .sck_out(sck_m), .ws_out(ws_m), .sd_out(sd_m));

  i2s_pingpong_tx #(.IS_MASTER(1'b0)) u_slv (
    .clk(clk), .rst_n(rst_n), .bus_stb(stb_s), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_ack(ack_s), .bus_rdata(rd_s), .irq(irq_s),
    .sck_in(sck_m), .ws_in(ws_m), .sck_out(sck_so), .ws_out(ws_so), .sd_out(sd_s));

  // ---------------- receiver model on the master bit clock ----------------
  logic [31:0] sh [2];
  logic [31:0] words [2][96];
  int  cnt [2];
  bit  cap [2], started [2];
  logic ws_last = 1'b0, sck_d = 1'b0;

  always @(negedge clk) begin
    if (sck_m && !sck_d) begin
      for (int s = 0; s < 2; s++) begin
        logic b;
        b = s ? sd_s : sd_m;
        if (ws_m != ws_last) begin
          logic [31:0] w;
          w = {sh[s][30:0], b};
          sh[s] = '0;
          if (cap[s] && (started[s] || w != 0) && cnt[s] < 96) begin
            started[s] = 1;
            words[s][cnt[s]] = w;
            cnt[s]++;
          end
        end else sh[s] = {sh[s][30:0], b};
      end
      ws_last = ws_m;
    end
    sck_d = sck_m;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input bit s, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    if (s) stb_s = 1'b1; else stb_m = 1'b1;
    @(negedge clk);
    stb_m = 1'b0; stb_s = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input bit s, input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    if (s) stb_s = 1'b1; else stb_m = 1'b1;
    @(negedge clk);
    d = s ? rd_s : rd_m;
    stb_m = 1'b0; stb_s = 1'b0;
  endtask

  function automatic logic [31:0] fill_word(input int i);
    return 32'h5A00_FFEE ^ (i * 257) ^ (i << 20);
  endfunction

  function automatic logic [31:0] exp_word(input int k, input int res);
    int r, idx;
    longint w, keep;
    r   = (res < 16) ? 16 : ((res > 32) ? 32 : res);
    idx = ((k / 2) % 16) * 2 + (k % 2);
    w   = longint'(fill_word(idx)) & 64'hFFFF_FFFF;
    keep = w % (64'd1 << r);
    return 32'(keep * (64'd1 << (32 - r)));
  endfunction

  task automatic run_stream(input bit s, input int res, input int div, input int frame_cyc);
    int guard, nz;
    bus_wr(s, 6'h1, {8'h00, 8'(res), 8'(div), 8'h00});
    repeat (2 * frame_cyc + 20) @(posedge clk);
    bus_wr(s, 6'h3, 32'h3);
    cnt[s] = 0; started[s] = 0; cap[s] = 1;
    bus_wr(s, 6'h1, {8'h00, 8'(res), 8'(div), 8'h01});
    guard = 0;
    while (cnt[s] < 34 && guard < 40 * frame_cyc) begin
      @(posedge clk); guard++;
    end
    bus_wr(s, 6'h1, {8'h00, 8'(res), 8'(div), 8'h00});
    repeat (3 * frame_cyc) @(posedge clk);
    cap[s] = 0;
    // R4 R5 R6: order, wrap and alignment of the first 34 decoded words
    for (int k = 0; k < 34; k++)
      chk($sformatf("R4 R5 R6 s%0d res%0d word%0d", s, res, k),
          (k < cnt[s]) ? words[s][k] : 32'hDEAD_0000, exp_word(k, res));
    // R9: the frame in progress completes, then only zeros
    nz = 0;
    while (nz < cnt[s] && words[s][nz] != 0) nz++;
    chk($sformatf("R9 s%0d whole frames before stop", s), 32'(nz % 2), 32'd0);
    begin
      int bad;
      bad = 0;
      for (int k = nz; k < cnt[s]; k++) if (words[s][k] != 0) bad++;
      chk($sformatf("R9 s%0d zeros after stop", s), 32'(bad), 32'd0);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] d;
    time t0, t1;
    for (int s = 0; s < 2; s++) begin
      sh[s] = '0; cnt[s] = 0; cap[s] = 0; started[s] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state and identity words
    @(negedge clk);
    chk("R1 irq after reset", 32'(irq_m), 32'd0);
    chk("R1 sd after reset", 32'(sd_m), 32'd0);
    bus_rd(0, 6'h3, d); chk("R1 status after reset", d, 32'h0);
    bus_rd(0, 6'h0, d); chk("R1 master id", d, 32'h1B1);
    bus_rd(1, 6'h0, d); chk("R1 slave id", d, 32'h191);
    bus_wr(0, 6'h0, 32'hFFFF_FFFF);
    bus_rd(0, 6'h0, d); chk("R1 id read-only", d, 32'h1B1);

    // R2: control and mask read back, ack is a single pulse
    bus_wr(0, 6'h1, 32'hFF18_01FE);
    bus_rd(0, 6'h1, d); chk("R2 control fields", d, 32'h0018_0100);
    @(negedge clk); chk("R2 ack single pulse", 32'(ack_m), 32'd0);
    bus_wr(0, 6'h2, 32'hFFFF_FFFF);
    bus_rd(0, 6'h2, d); chk("R2 mask read back", d, 32'h3);

    // R3: fill both sample memories and read back the master one
    for (int i = 0; i < 32; i++) begin
      bus_wr(0, 6'(32 + i), fill_word(i));
      bus_wr(1, 6'(32 + i), fill_word(i));
    end
    for (int i = 0; i < 32; i++) begin
      bus_rd(0, 6'(32 + i), d);
      chk($sformatf("R3 buffer word %0d", i), d, fill_word(i));
    end

    // Main stream at 24 bits, divider 1
    run_stream(0, 24, 1, 256);

    // R7 R8: status flags, write-one-to-clear, interrupt
    bus_rd(0, 6'h3, d); chk("R7 both halves flagged", d, 32'h3);
    @(negedge clk); chk("R8 irq with both enabled", 32'(irq_m), 32'd1);
    bus_wr(0, 6'h3, 32'h1);
    bus_rd(0, 6'h3, d); chk("R7 clear low half only", d, 32'h2);
    chk("R8 irq still high", 32'(irq_m), 32'd1);
    bus_wr(0, 6'h3, 32'h0);
    bus_rd(0, 6'h3, d); chk("R7 writing zero keeps bit", d, 32'h2);
    bus_wr(0, 6'h3, 32'h2);
    bus_rd(0, 6'h3, d); chk("R7 clear high half", d, 32'h0);
    chk("R8 irq low after clear", 32'(irq_m), 32'd0);

    // R6: resolution sweep including clamped setting
    run_stream(0, 16, 1, 256);
    run_stream(0, 20, 1, 256);
    run_stream(0, 32, 1, 256);
    run_stream(0, 8, 1, 256);

    // R8: masking
    bus_wr(0, 6'h2, 32'h0);
    run_stream(0, 32, 1, 256);
    bus_rd(0, 6'h3, d); chk("R7 flags set while masked", d, 32'h3);
    chk("R8 irq low when masked", 32'(irq_m), 32'd0);
    bus_wr(0, 6'h2, 32'h2);
    @(negedge clk); chk("R8 irq via high-half mask", 32'(irq_m), 32'd1);
    bus_wr(0, 6'h3, 32'h2);
    @(negedge clk); chk("R8 irq low, low half unmasked", 32'(irq_m), 32'd0);

    // R10: bit clock period from the divider
    @(posedge sck_m); t0 = $time; @(posedge sck_m); t1 = $time;
    chk("R10 period divider 1", 32'((t1 - t0) / 5ns), 32'd4);
    bus_wr(0, 6'h1, 32'h0018_0300);
    repeat (20) @(posedge clk);
    @(posedge sck_m); t0 = $time; @(posedge sck_m); t1 = $time;
    chk("R10 period divider 3", 32'((t1 - t0) / 5ns), 32'd8);

    // R11: slave follows the master clocks, divider 3
    chk("R11 slave sck_out held low", 32'(sck_so), 32'd0);
    chk("R11 slave ws_out held low", 32'(ws_so), 32'd0);
    run_stream(1, 24, 0, 512);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule